// File: doc/BRIEF.md
# Word-Aligned Hybrid Bitmap Atom Expander

This block turns a stream of compressed bitmap atoms into a stream of plain 64-bit bitmap words. Each 64-bit input atom is either a literal, which carries one 63-bit chunk verbatim, or a run, which stands for a number of identical 63-bit chunks that are all zeros or all ones. For every chunk the block produces one output word, with bit 63 always clear. Both sides use a valid/ready handshake, so a downstream stall holds the current word and stops the input.

A run is loaded into a down-counter and gives one word per accepted output beat until the counter is exhausted. Only then is the next atom taken. A run of length zero is accepted and dropped in a single cycle. An end-of-vector marker on an input atom is carried to the last word that atom produces. A running tally of delivered words is kept. From it the block also reports the bitmap row index of bit 0 of the word on the output, which is 63 times the number of words already delivered.

Top module: `wah_expander`

## Requirements
- R1: An atom with bit 63 equal to 0 (literal) produces exactly one output word, equal to the atom unchanged, on the cycle after it is accepted.
- R2: An atom with bit 63 equal to 1 (run) produces as many output words as the unsigned value of its bits 61:0.
- R3: A run whose bit 62 is 0 produces output words that are all zero.
- R4: A run whose bit 62 is 1 produces output words with bit 63 at 0 and bits 62:0 all 1; no output word ever has bit 63 set.
- R5: A run whose length bits are all zero produces no output word, is accepted in one cycle, and leaves out_valid low on the following cycle when nothing else is pending.
- R6: While out_valid is high and out_ready is low, out_word, out_last and out_valid stay unchanged into the next cycle.
- R7: in_ready is high exactly when no output word is pending, or when the pending word is the final word of its atom and out_ready is high.
- R8: out_last is high only on the final output word of an atom whose in_last was high; a zero-length run with in_last high produces no word and so no out_last.
- R9: out_count equals the number of output words delivered since reset (starting at 0), and out_row equals 63 times out_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input atom is valid |
| in_ready | output | 1 | Block will take the input atom this cycle |
| in_atom | input | 64 | Compressed atom: bit 63 run flag, bit 62 run value, bits 61:0 run length |
| in_last | input | 1 | Atom is the last of its bit vector |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream takes the output word this cycle |
| out_word | output | 64 | Expanded bitmap word, bit 63 always 0 |
| out_last | output | 1 | Final word of the vector |
| out_count | output | CNT_W | Number of words delivered since reset |
| out_row | output | CNT_W+6 | Bitmap row of bit 0 of the current output word |

## Verification
The bench goes after zero-length runs, which a careless design would either emit as one word or stall on. It also covers runs of length one, which share the same-cycle reload path with literals, and long runs held under random stalls, where a faulty counter loses or repeats a word or lets the next atom in early. It checks end-of-vector markers on runs and on zero-length runs, where a wrong design would flag the first word of the run or invent a flagged word. It checks ones-runs, where a design that copied the flag bits would leave bit 63 set. The word tally and row index are compared on every delivered word, so an off-by-one in either shows up at once.

// File: rtl/wah_pkg.sv
package wah_pkg;
  localparam int unsigned ATOM_W   = 64;
  localparam int unsigned CHUNK_W  = 63;
  localparam int unsigned RUN_LEN_W = 62;
  localparam int unsigned RUN_FLAG_BIT = 63;
  localparam int unsigned RUN_VAL_BIT  = 62;

  typedef logic [ATOM_W-1:0] word_t;

  function automatic logic atom_is_run(input word_t a);
    return a[RUN_FLAG_BIT];
  endfunction

  function automatic logic atom_run_value(input word_t a);
    return a[RUN_VAL_BIT];
  endfunction

  // Word produced for every chunk of a run: top bit clear, chunk bits replicate the value.
  function automatic word_t run_word(input logic value);
    word_t w;
    w = '0;
    w[CHUNK_W-1:0] = {CHUNK_W{value}};
    return w;
  endfunction
endpackage

// File: rtl/wah_atom_decode.sv
module wah_atom_decode
  import wah_pkg::*;
#(
  parameter int unsigned LEN_W = 62
) (
  input  word_t             atom,
  output word_t             first_word,
  output logic [LEN_W-1:0]  beats,
  output logic              no_beats
);
  localparam int unsigned USE_W = (LEN_W < RUN_LEN_W) ? LEN_W : RUN_LEN_W;

  logic [LEN_W-1:0] run_beats;

  always_comb begin
    run_beats = '0;
    run_beats[USE_W-1:0] = atom[USE_W-1:0];
  end

  always_comb begin
    if (atom_is_run(atom)) begin
      first_word = run_word(atom_run_value(atom));
      beats      = run_beats;
    end else begin
      first_word = atom;
      beats      = LEN_W'(1);
    end
    no_beats = (beats == '0);
  end
endmodule

// File: rtl/wah_run_counter.sv
module wah_run_counter
  import wah_pkg::*;
#(
  parameter int unsigned LEN_W = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  word_t            load_word,
  input  logic [LEN_W-1:0] load_beats,
  input  logic             load_last,
  input  logic             take,
  output logic             busy,
  output word_t            word,
  output logic             final_beat,
  output logic             vec_last
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain   <= '0;
      word     <= '0;
      vec_last <= 1'b0;
    end else if (load) begin
      busy     <= (load_beats != '0);
      remain   <= load_beats;
      word     <= load_word;
      vec_last <= load_last;
    end else if (take) begin
      remain <= remain - LEN_W'(1);
      if (final_beat) busy <= 1'b0;
    end
  end

  assign final_beat = (remain == LEN_W'(1));
endmodule

// File: rtl/wah_word_tally.sv
module wah_word_tally #(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned ROW_W = CNT_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] wide;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (step) count <= count + CNT_W'(1);
  end

  // 63 * count as a shift and a subtract
  assign wide = ROW_W'(count);
  assign row  = (wide << 6) - wide;
endmodule

// File: rtl/wah_expander.sv
module wah_expander
  import wah_pkg::*;
#(
  parameter int unsigned LEN_W = 62,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned ROW_W = CNT_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_atom,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_word,
  output logic             out_last,
  output logic [CNT_W-1:0] out_count,
  output logic [ROW_W-1:0] out_row
);
  // named internal events
  logic             in_fire;
  logic             out_fire;
  logic             run_final;
  logic             run_busy;
  logic             run_vec_last;
  word_t            dec_word;
  logic [LEN_W-1:0] dec_beats;
  logic             dec_empty;
  word_t            run_word_q;

  wah_atom_decode #(.LEN_W(LEN_W)) u_dec (
    .atom       (in_atom),
    .first_word (dec_word),
    .beats      (dec_beats),
    .no_beats   (dec_empty)
  );

  wah_run_counter #(.LEN_W(LEN_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (in_fire),
    .load_word  (dec_word),
    .load_beats (dec_beats),
    .load_last  (in_last),
    .take       (out_fire),
    .busy       (run_busy),
    .word       (run_word_q),
    .final_beat (run_final),
    .vec_last   (run_vec_last)
  );

  wah_word_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (out_fire),
    .count (out_count),
    .row   (out_row)
  );

  assign out_valid = run_busy;
  assign out_word  = run_word_q;
  assign out_last  = run_busy & run_final & run_vec_last;
  assign out_fire  = out_valid & out_ready;
  assign in_ready  = ~run_busy | (out_ready & run_final);
  assign in_fire   = in_valid & in_ready;
endmodule

// File: rtl/wah_expander_chk.sv
module wah_expander_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [63:0]      in_atom,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_word,
  input logic             out_last,
  input logic [CNT_W-1:0] out_count
);
  // R1
  a_r1_literal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_atom[63]) |=> (out_valid && out_word == $past(in_atom)));

  // R4
  a_r4_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_word[63]);

  // R5
  a_r5_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_atom[63] && in_atom[61:0] == 62'd0) |=> !out_valid);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  // R7
  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (out_count == $past(out_count) + CNT_W'(1)));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(out_count));
endmodule

bind wah_expander wah_expander_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_atom   (in_atom),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_last  (out_last),
  .out_count (out_count)
);

// File: tb/sim_wah_expander.sv
module sim_wah_expander;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int ROW_W = CNT_W + 6;
  localparam int WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [63:0]      in_atom = '0;
  logic             in_last = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [63:0]      out_word;
  logic             out_last;
  logic [CNT_W-1:0] out_count;
  logic [ROW_W-1:0] out_row;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int stall_pct = 30;
  logic [63:0] exp_w[$];
  logic        exp_l[$];
  longint unsigned delivered = 0;
  logic        held_v = 1'b0;
  logic [63:0] held_w = '0;
  logic        held_l = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wah_expander #(.LEN_W(62), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_atom(in_atom), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_last(out_last),
    .out_count(out_count), .out_row(out_row)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] make_run(input logic value, input longint unsigned len);
    return {1'b1, value, len[61:0]};
  endfunction

  // Bench model: words an atom stands for
  task automatic model_push(input logic [63:0] a, input logic last);
    longint unsigned n;
    logic [63:0] w;
    if (!a[63]) begin
      n = 1; w = a;
    end else begin
      n = longint'(a[61:0]);
      w = a[62] ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0;
    end
    for (longint unsigned i = 0; i < n; i++) begin
      exp_w.push_back(w);
      exp_l.push_back(last && (i == n - 1));
    end
  endtask

  task automatic send(input logic [63:0] a, input logic last);
    in_valid = 1'b1; in_atom = a; in_last = last;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    model_push(a, last);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_w.size() != 0 || out_valid) @(negedge clk);
  endtask

  // Consumer and per-cycle checks
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (held_v) begin
        check(out_valid && out_word == held_w && out_last == held_l, "R6 hold under stall",
              {out_valid, out_word[62:0]}, {1'b1, held_w[62:0]});
      end
      held_v = out_valid && !out_ready;
      held_w = out_word; held_l = out_last;
      check(in_ready == (exp_w.size() == 0 || (exp_w.size() == 1 && out_ready)),
            "R7 input gating", 64'(in_ready), 64'(exp_w.size() == 0 || (exp_w.size() == 1 && out_ready)));
      if (out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R2 unexpected extra word", out_word, 64'h0);
        end else begin
          logic [63:0] ew;
          logic el;
          ew = exp_w.pop_front();
          el = exp_l.pop_front();
          check(out_word == ew, "R1/R2/R3/R4 word value", out_word, ew);
          check(out_last == el, "R8 last flag", 64'(out_last), 64'(el));
          check(out_count == CNT_W'(delivered), "R9 word count", 64'(out_count), delivered);
          check(out_row == ROW_W'(delivered * 63), "R9 row index", 64'(out_row), delivered * 63);
          delivered++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        check(1'b0, "watchdog", 64'(cycles), 64'(WATCHDOG));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready && out_count == 0 && out_row == 0, "R9 reset state",
          {62'd0, out_valid, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: literal with bit 62 set, run of one, zero runs, ones runs
    send(64'h4123_4567_89AB_CDEF, 1'b0);           // R1
    send(make_run(1'b1, 1), 1'b0);                  // R4
    send(make_run(1'b0, 3), 1'b1);                  // R3 R8
    send(make_run(1'b1, 5), 1'b1);                  // R4 R8
    send(64'h0000_0000_0000_0001, 1'b1);            // R1 R8

    // Directed: zero-length run, nothing pending -> no word next cycle (R5)
    drain();
    send(make_run(1'b1, 0), 1'b1);
    check(!out_valid, "R5 empty run emits nothing", 64'(out_valid), 64'd0);
    check(out_count == CNT_W'(delivered), "R5 count unchanged", 64'(out_count), delivered);
    send(make_run(1'b0, 0), 1'b0);
    check(!out_valid && in_ready, "R5 empty run consumed in one cycle",
          {62'd0, out_valid, in_ready}, 64'd1);

    // Directed: long run under heavy stall (R6 R7)
    stall_pct = 80;
    send(make_run(1'b1, 20), 1'b0);
    send(64'h2AAA_5555_0F0F_F0F0, 1'b1);
    drain();
    stall_pct = 30;

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      int kind;
      kind = $urandom_range(9);
      if (kind < 4) a = {1'b0, $urandom(), $urandom()} & 64'h7FFF_FFFF_FFFF_FFFF;
      else if (kind < 5) a = make_run($urandom_range(1), 0);
      else if (kind < 9) a = make_run($urandom_range(1), $urandom_range(1, 6));
      else a = make_run($urandom_range(1), $urandom_range(7, 40));
      if (k % 50 == 0) stall_pct = $urandom_range(0, 70);
      if ($urandom_range(3) == 0) @(negedge clk);
      send(a, $urandom_range(5) == 0);
    end
    drain();
    repeat (3) @(negedge clk);
    check(exp_w.size() == 0 && !out_valid, "R2 all words delivered", 64'(exp_w.size()), 64'd0);
    check(out_count == CNT_W'(delivered), "R9 final count", 64'(out_count), delivered);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule